// File: doc/BRIEF.md
# Translation-Buffer Miss Refill Walker

This block services a miss in the address-translation buffer by walking a single-level page table that lives in main memory. When the buffer misses, it passes the walker the missing virtual page number and a description of the entry chosen for eviction: its tag (the victim's virtual page number), its valid flag, and its use and dirty bits. The walker stores the victim's use and dirty bits into that victim's page-table word. It then fetches the page-table word for the missing page and acts on that word's valid bit.

If the fetched word is valid, the walker presents the new translation on the buffer's fill port for one cycle and, in the same cycle, pulses a retry strobe so the stalled access can be reissued. If the word is not valid, it pulses a page-fault strobe for software and leaves the buffer untouched. Each page-table slot is one 32-bit word. Its address is the page-table base register plus the virtual page number times the slot size in bytes.

Memory is reached through a request/acknowledge port that carries a per-bit write mask. The status write-back therefore changes only the two status bits and needs no read-modify-write. Disk paging and the operating system's replacement policy sit outside this block.

Top module: `tlb_refill_fsm`

## Requirements
- R1: After a miss is accepted with a valid victim, the first memory access is a write to `pt_base + 4*victim_vpn`. Its data carries the victim use bit at bit 28 and the dirty bit at bit 29, and its mask is exactly 32'h3000_0000. The next access is a read of `pt_base + 4*miss_vpn`. Page-table slots are 4 bytes.
- R2: When the victim is marked not valid, no write is issued, and the read of the requested slot is the only access.
- R3: While `mem_req` is high and `mem_ack` is low, `mem_addr`, `mem_we`, `mem_wdata` and `mem_wmask` stay unchanged, for any number of wait cycles.
- R4: If bit 31 (valid) of the fetched word is 1, then in the cycle after the read acknowledge `fill_valid` and `retry` are high for exactly one cycle. In that cycle `fill_vpn` is the missing page, `fill_ppn` is bits 21:0, `fill_prot` is bit 30, `fill_dirty` is bit 29 and `fill_use` is bit 28.
- R5: If bit 31 of the fetched word is 0, then in the cycle after the read acknowledge `page_fault` is high for one cycle, and `fill_valid` and `retry` stay low.
- R6: `busy` is high from the cycle after an accepted `miss_valid` up to and including the cycle of the `retry` or `page_fault` pulse, and low in the following cycle.
- R7: A `miss_valid` that arrives while `busy` is high has no effect. It starts no memory access and produces no extra pulse.
- R8: During reset, `busy`, `mem_req`, `fill_valid`, `retry` and `page_fault` are low.
- R9: A new miss is accepted in the first cycle in which `busy` is low after a completed walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| miss_valid | input | 1 | Miss strobe from the translation buffer |
| miss_vpn | input | VPN_W | Virtual page number that missed |
| vic_valid | input | 1 | Victim entry holds a live translation |
| vic_vpn | input | VPN_W | Victim tag (its virtual page number) |
| vic_use | input | 1 | Victim use bit |
| vic_dirty | input | 1 | Victim dirty bit |
| pt_base | input | ADDR_W | Page-table base register |
| busy | output | 1 | Walk in progress |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W | Byte address of the page-table slot |
| mem_wdata | output | 32 | Write data |
| mem_wmask | output | 32 | Per-bit write enable |
| mem_ack | input | 1 | Memory acknowledge |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| fill_valid | output | 1 | Load the translation into the buffer |
| fill_vpn | output | VPN_W | Tag of the new translation |
| fill_ppn | output | PPN_W | Physical page number |
| fill_prot | output | 1 | Protection bit |
| fill_dirty | output | 1 | Dirty bit |
| fill_use | output | 1 | Use bit |
| retry | output | 1 | Reissue the stalled access |
| page_fault | output | 1 | Requested page not resident |

## Verification
Some properties are checked on every cycle. The request fields must stay stable while the walker waits for an acknowledge. A write acknowledge must be followed by a read. Each retry or fault pulse must follow a read acknowledge whose valid bit matches the pulse. `busy` must rise after an accepted strobe and fall after a pulse. Other behaviour can only be shown by the bench's scenarios. These are the exact addresses, data and mask of each access, the contents of the victim's word after the masked write, the decoded fill fields, that the write is dropped for a dead victim, and that strobes arriving while busy are ignored.

// File: rtl/tlb_refill_pkg.sv
package tlb_refill_pkg;
   localparam int PTE_W         = 32;
   localparam int PTE_USE_BIT   = 28;
   localparam int PTE_DIRTY_BIT = 29;
   localparam int PTE_PROT_BIT  = 30;
   localparam int PTE_VALID_BIT = 31;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_WBACK,
      ST_FETCH,
      ST_LOAD,
      ST_FAULT
   } walk_st_e;
endpackage

// File: rtl/pte_addr_gen.sv
module pte_addr_gen #(
   parameter int ADDR_W    = 32,
   parameter int VPN_W     = 26,
   parameter int PTE_BYTES = 4
) (
   input  logic [ADDR_W-1:0] base,
   input  logic [VPN_W-1:0]  vpn,
   output logic [ADDR_W-1:0] addr
);
   localparam int SHIFT = $clog2(PTE_BYTES);

   if ((1 << SHIFT) != PTE_BYTES) begin : g_bad_size
      $error("PTE_BYTES must be a power of two");
   end
   if (VPN_W + SHIFT > ADDR_W) begin : g_bad_width
      $error("scaled VPN does not fit in ADDR_W");
   end

   if (SHIFT == 0) begin : g_noscale
      assign addr = base + ADDR_W'(vpn);
   end else begin : g_scale
      assign addr = base + (ADDR_W'(vpn) << SHIFT);
   end
endmodule

// File: rtl/pte_codec.sv
module pte_codec
   import tlb_refill_pkg::*;
#(
   parameter int PPN_W = 22
) (
   input  logic [PTE_W-1:0] pte,
   input  logic             wb_use,
   input  logic             wb_dirty,
   output logic [PPN_W-1:0] ppn,
   output logic             valid,
   output logic             prot,
   output logic             dirty,
   output logic             use_b,
   output logic [PTE_W-1:0] wb_data,
   output logic [PTE_W-1:0] wb_mask
);
   if (PPN_W > PTE_USE_BIT) begin : g_bad_ppn
      $error("PPN_W overlaps the status bits");
   end

   assign ppn   = pte[PPN_W-1:0];
   assign valid = pte[PTE_VALID_BIT];
   assign prot  = pte[PTE_PROT_BIT];
   assign dirty = pte[PTE_DIRTY_BIT];
   assign use_b = pte[PTE_USE_BIT];

   if (PPN_W < PTE_USE_BIT) begin : g_rsvd
      logic unused_rsvd;
      assign unused_rsvd = ^pte[PTE_USE_BIT-1:PPN_W];
   end

   always_comb begin
      wb_data                = '0;
      wb_mask                = '0;
      wb_data[PTE_USE_BIT]   = wb_use;
      wb_data[PTE_DIRTY_BIT] = wb_dirty;
      wb_mask[PTE_USE_BIT]   = 1'b1;
      wb_mask[PTE_DIRTY_BIT] = 1'b1;
   end
endmodule

// File: rtl/tlb_refill_fsm.sv
module tlb_refill_fsm
   import tlb_refill_pkg::*;
#(
   parameter int VPN_W     = 26,
   parameter int PPN_W     = 22,
   parameter int ADDR_W    = 32,
   parameter int PTE_BYTES = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              miss_valid,
   input  logic [VPN_W-1:0]  miss_vpn,
   input  logic              vic_valid,
   input  logic [VPN_W-1:0]  vic_vpn,
   input  logic              vic_use,
   input  logic              vic_dirty,
   input  logic [ADDR_W-1:0] pt_base,
   output logic              busy,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [31:0]       mem_wdata,
   output logic [31:0]       mem_wmask,
   input  logic              mem_ack,
   input  logic [31:0]       mem_rdata,
   output logic              fill_valid,
   output logic [VPN_W-1:0]  fill_vpn,
   output logic [PPN_W-1:0]  fill_ppn,
   output logic              fill_prot,
   output logic              fill_dirty,
   output logic              fill_use,
   output logic              retry,
   output logic              page_fault
);
   walk_st_e          state_q;
   logic [VPN_W-1:0]  req_vpn_q, vic_vpn_q;
   logic              vic_use_q, vic_dirty_q;
   logic [ADDR_W-1:0] base_q;
   logic [PTE_W-1:0]  pte_q;
   logic [ADDR_W-1:0] vic_addr, req_addr;
   logic [PTE_W-1:0]  wb_data, wb_mask;
   logic              pte_valid_unused;

   pte_addr_gen #(.ADDR_W(ADDR_W), .VPN_W(VPN_W), .PTE_BYTES(PTE_BYTES)) u_vic_addr (
      .base(base_q), .vpn(vic_vpn_q), .addr(vic_addr));

   pte_addr_gen #(.ADDR_W(ADDR_W), .VPN_W(VPN_W), .PTE_BYTES(PTE_BYTES)) u_req_addr (
      .base(base_q), .vpn(req_vpn_q), .addr(req_addr));

   pte_codec #(.PPN_W(PPN_W)) u_codec (
      .pte(pte_q), .wb_use(vic_use_q), .wb_dirty(vic_dirty_q),
      .ppn(fill_ppn), .valid(pte_valid_unused), .prot(fill_prot),
      .dirty(fill_dirty), .use_b(fill_use),
      .wb_data(wb_data), .wb_mask(wb_mask));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         req_vpn_q   <= '0;
         vic_vpn_q   <= '0;
         vic_use_q   <= 1'b0;
         vic_dirty_q <= 1'b0;
         base_q      <= '0;
         pte_q       <= '0;
      end else begin
         case (state_q)
            ST_IDLE: if (miss_valid) begin
               req_vpn_q   <= miss_vpn;
               vic_vpn_q   <= vic_vpn;
               vic_use_q   <= vic_use;
               vic_dirty_q <= vic_dirty;
               base_q      <= pt_base;
               state_q     <= vic_valid ? ST_WBACK : ST_FETCH;
            end
            ST_WBACK: if (mem_ack) state_q <= ST_FETCH;
            ST_FETCH: if (mem_ack) begin
               pte_q   <= mem_rdata;
               state_q <= mem_rdata[PTE_VALID_BIT] ? ST_LOAD : ST_FAULT;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      busy       = (state_q != ST_IDLE);
      mem_req    = (state_q == ST_WBACK) || (state_q == ST_FETCH);
      mem_we     = (state_q == ST_WBACK);
      mem_addr   = mem_we ? vic_addr : req_addr;
      mem_wdata  = wb_data;
      mem_wmask  = mem_we ? wb_mask : '0;
      fill_valid = (state_q == ST_LOAD);
      retry      = (state_q == ST_LOAD);
      page_fault = (state_q == ST_FAULT);
      fill_vpn   = req_vpn_q;
   end
endmodule

// File: rtl/tlb_refill_chk.sv
module tlb_refill_chk #(
   parameter int ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              miss_valid,
   input logic              busy,
   input logic              mem_req,
   input logic              mem_we,
   input logic              mem_ack,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [31:0]       mem_wdata,
   input logic [31:0]       mem_wmask,
   input logic              rd_valid_bit,
   input logic              fill_valid,
   input logic              retry,
   input logic              page_fault
);
   assert_hold_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                  && $stable(mem_wdata) && $stable(mem_wmask)));

   assert_write_then_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we && mem_ack) |=> (mem_req && !mem_we));

   assert_fill_after_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
      fill_valid |-> $past(mem_req && mem_ack && !mem_we && rd_valid_bit));

   assert_fault_after_invalid_R5: assert property (@(posedge clk) disable iff (!rst_n)
      page_fault |-> $past(mem_req && mem_ack && !mem_we && !rd_valid_bit));

   assert_busy_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && miss_valid) |=> busy);

   assert_busy_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (retry || page_fault) |=> !busy);

   assert_busy_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !retry && !page_fault) |=> busy);
endmodule

bind tlb_refill_fsm tlb_refill_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .busy(busy),
   .mem_req(mem_req), .mem_we(mem_we), .mem_ack(mem_ack), .mem_addr(mem_addr),
   .mem_wdata(mem_wdata), .mem_wmask(mem_wmask), .rd_valid_bit(mem_rdata[31]),
   .fill_valid(fill_valid), .retry(retry), .page_fault(page_fault));

// File: tb/tlb_refill_fsm_tb.sv
`timescale 1ns/1ps
module tlb_refill_fsm_tb;
   localparam int VPN_W = 26, PPN_W = 22, ADDR_W = 32;
   localparam logic [31:0] BASE     = 32'h0001_0000;
   localparam logic [31:0] VIC_INIT = 32'hBF00_0000;
   localparam logic [31:0] WB_MASK  = 32'h3000_0000;

   typedef struct packed {
      logic [7:0]  mvpn;
      logic [7:0]  vvpn;
      logic        vv;
      logic        vu;
      logic        vd;
      logic [31:0] pte;
      logic [3:0]  wt;
   } vec_t;

   localparam vec_t VECS [6] = '{
      '{8'h12, 8'h05, 1'b1, 1'b1, 1'b0, 32'hC000_0ABC, 4'd0},
      '{8'h20, 8'h21, 1'b1, 1'b1, 1'b1, 32'h8000_1234, 4'd3},
      '{8'h33, 8'h00, 1'b0, 1'b0, 1'b0, 32'hB03F_FFFF, 4'd2},
      '{8'h44, 8'h07, 1'b1, 1'b0, 1'b1, 32'h4000_0001, 4'd1},
      '{8'h55, 8'h09, 1'b0, 1'b1, 1'b1, 32'h0000_0000, 4'd5},
      '{8'hFF, 8'hFE, 1'b1, 1'b0, 1'b0, 32'h9000_0001, 4'd7}
   };

   logic clk = 0, rst_n = 0;
   logic miss_valid = 0, vic_valid = 0, vic_use = 0, vic_dirty = 0;
   logic [VPN_W-1:0] miss_vpn = '0, vic_vpn = '0;
   logic [ADDR_W-1:0] pt_base = BASE;
   logic busy, mem_req, mem_we, mem_ack = 0;
   logic [ADDR_W-1:0] mem_addr;
   logic [31:0] mem_wdata, mem_wmask, mem_rdata = '0;
   logic fill_valid, fill_prot, fill_dirty, fill_use, retry, page_fault;
   logic [VPN_W-1:0] fill_vpn;
   logic [PPN_W-1:0] fill_ppn;

   always #4 clk = ~clk;

   tlb_refill_fsm u_dut (
      .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_vpn(miss_vpn),
      .vic_valid(vic_valid), .vic_vpn(vic_vpn), .vic_use(vic_use), .vic_dirty(vic_dirty),
      .pt_base(pt_base), .busy(busy), .mem_req(mem_req), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_wmask(mem_wmask),
      .mem_ack(mem_ack), .mem_rdata(mem_rdata), .fill_valid(fill_valid),
      .fill_vpn(fill_vpn), .fill_ppn(fill_ppn), .fill_prot(fill_prot),
      .fill_dirty(fill_dirty), .fill_use(fill_use), .retry(retry), .page_fault(page_fault));

   int errors = 0, checks = 0;
   int cyc = 0, wait_cfg = 0, cnt = 0;
   int n_acc = 0, pulses = 0, rd_ack_cyc = 0, pulse_cyc = 0;
   logic [31:0] pt_mem [256];
   logic [31:0] log_addr [4], log_wdata [4], log_mask [4];
   logic        log_we [4];
   logic [31:0] hold_addr, hold_wdata, hold_mask;
   logic        hold_we;
   logic        p_retry, p_fault, p_fill;
   logic [VPN_W-1:0] p_vpn;
   logic [PPN_W-1:0] p_ppn;
   logic p_prot, p_dirty, p_use;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // memory model and pulse monitor
   always @(negedge clk) begin
      cyc++;
      if (mem_ack) begin
         mem_ack = 0;
         cnt = 0;
      end else if (mem_req) begin
         if (cnt > 0)
            chk(mem_addr == hold_addr && mem_we == hold_we && mem_wdata == hold_wdata
                && mem_wmask == hold_mask, "R3", "request held during wait",
                {mem_wdata, mem_addr}, {hold_wdata, hold_addr});
         hold_addr = mem_addr; hold_we = mem_we;
         hold_wdata = mem_wdata; hold_mask = mem_wmask;
         if (cnt == wait_cfg) begin
            mem_ack = 1;
            if (n_acc < 4) begin
               log_addr[n_acc] = mem_addr; log_we[n_acc] = mem_we;
               log_wdata[n_acc] = mem_wdata; log_mask[n_acc] = mem_wmask;
            end
            n_acc++;
            if (mem_we)
               pt_mem[8'((mem_addr - BASE) >> 2)] =
                  (pt_mem[8'((mem_addr - BASE) >> 2)] & ~mem_wmask) | (mem_wdata & mem_wmask);
            else begin
               mem_rdata = pt_mem[8'((mem_addr - BASE) >> 2)];
               rd_ack_cyc = cyc;
            end
         end else cnt++;
      end
      if (retry || page_fault || fill_valid) begin
         pulses++; pulse_cyc = cyc;
         p_retry = retry; p_fault = page_fault; p_fill = fill_valid;
         p_vpn = fill_vpn; p_ppn = fill_ppn;
         p_prot = fill_prot; p_dirty = fill_dirty; p_use = fill_use;
      end
   end

   task automatic tick();
      @(negedge clk); #1;
   endtask

   // Issue one miss and check the whole walk against the requirements.
   task automatic run_miss(input vec_t v);
      int p0;
      logic [31:0] vic_exp;
      pt_mem[v.vvpn] = VIC_INIT | 32'(v.vvpn);
      pt_mem[v.mvpn] = v.pte;
      wait_cfg = int'(v.wt);
      n_acc = 0; p0 = pulses;
      miss_vpn = VPN_W'(v.mvpn); vic_vpn = VPN_W'(v.vvpn);
      vic_valid = v.vv; vic_use = v.vu; vic_dirty = v.vd;
      miss_valid = 1;
      tick();
      miss_valid = 0;
      chk(busy == 1, "R9", "new miss accepted, busy", 64'(busy), 1);
      for (int i = 0; i < 300 && pulses == p0; i++) tick();
      chk(pulses == p0 + 1, "R6", "one completion pulse", 64'(pulses - p0), 1);
      chk(busy == 1, "R6", "busy in pulse cycle", 64'(busy), 1);
      chk(pulse_cyc == rd_ack_cyc + 1, "R4", "pulse one cycle after read ack",
          64'(pulse_cyc), 64'(rd_ack_cyc + 1));
      if (v.pte[31]) begin
         chk(p_retry && p_fill && !p_fault, "R4", "retry with fill",
             {p_retry, p_fill, p_fault}, 3'b110);
         chk(p_vpn == VPN_W'(v.mvpn), "R4", "fill_vpn", 64'(p_vpn), 64'(v.mvpn));
         chk(p_ppn == v.pte[21:0], "R4", "fill_ppn", 64'(p_ppn), 64'(v.pte[21:0]));
         chk({p_prot, p_dirty, p_use} == v.pte[30:28], "R4", "fill status",
             {p_prot, p_dirty, p_use}, v.pte[30:28]);
      end else
         chk(p_fault && !p_fill && !p_retry, "R5", "fault without fill",
             {p_fault, p_fill, p_retry}, 3'b100);
      chk(n_acc == (v.vv ? 2 : 1), v.vv ? "R1" : "R2", "access count", 64'(n_acc), v.vv ? 2 : 1);
      if (v.vv) begin
         chk(log_we[0] && log_addr[0] == BASE + 32'(v.vvpn) * 4, "R1", "write-back address",
             log_addr[0], BASE + 32'(v.vvpn) * 4);
         chk(log_mask[0] == WB_MASK && (log_wdata[0] & WB_MASK) == {2'b0, v.vd, v.vu, 28'b0},
             "R1", "write-back data/mask", {log_mask[0], log_wdata[0]},
             {WB_MASK, 2'b0, v.vd, v.vu, 28'b0});
         vic_exp = ((VIC_INIT | 32'(v.vvpn)) & ~WB_MASK) | {2'b0, v.vd, v.vu, 28'b0};
         chk(pt_mem[v.vvpn] == vic_exp, "R1", "victim word after write", pt_mem[v.vvpn], vic_exp);
         chk(!log_we[1] && log_addr[1] == BASE + 32'(v.mvpn) * 4, "R1", "read after write",
             log_addr[1], BASE + 32'(v.mvpn) * 4);
      end else begin
         chk(!log_we[0] && log_addr[0] == BASE + 32'(v.mvpn) * 4, "R2", "read only",
             log_addr[0], BASE + 32'(v.mvpn) * 4);
         chk(pt_mem[v.vvpn] == (VIC_INIT | 32'(v.vvpn)), "R2", "victim word untouched",
             pt_mem[v.vvpn], VIC_INIT | 32'(v.vvpn));
      end
      tick();
      chk(busy == 0, "R6", "busy low after pulse", 64'(busy), 0);
   endtask

   initial begin
      for (int i = 0; i < 256; i++) pt_mem[i] = '0;
      repeat (3) tick();
      chk({busy, mem_req, fill_valid, retry, page_fault} == 5'b0, "R8", "outputs in reset",
          {busy, mem_req, fill_valid, retry, page_fault}, 0);
      rst_n = 1;
      tick();
      chk(busy == 0 && mem_req == 0, "R8", "idle after reset", {busy, mem_req}, 0);

      foreach (VECS[k]) run_miss(VECS[k]);

      // R7: strobes during a walk are ignored
      begin
         vec_t v;
         int p0;
         v = '{8'h60, 8'h61, 1'b1, 1'b1, 1'b1, 32'h8000_0777, 4'd12};
         pt_mem[v.vvpn] = VIC_INIT; pt_mem[v.mvpn] = v.pte; pt_mem[8'h70] = 32'h8000_0001;
         wait_cfg = 12; n_acc = 0; p0 = pulses;
         miss_vpn = 26'h60; vic_vpn = 26'h61; vic_valid = 1; miss_valid = 1;
         tick();
         miss_vpn = 26'h70; vic_vpn = 26'h71;
         for (int i = 0; i < 10; i++) tick();
         miss_valid = 0;
         for (int i = 0; i < 100 && pulses == p0; i++) tick();
         chk(p_vpn == 26'h60 && p_ppn == 22'h777, "R7", "walk kept first miss",
             {p_vpn, p_ppn}, {26'h60, 22'h777});
         repeat (6) tick();
         chk(n_acc == 2, "R7", "no extra accesses", 64'(n_acc), 2);
         chk(pulses == p0 + 1 && busy == 0, "R7", "no extra pulse",
             64'(pulses - p0), 1);
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(8 * 150000);
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule